// File: doc/BRIEF.md
# Write-Cycle Status Read Multiplexer

This block forms the read-data path of a byte-wide nonvolatile memory that runs timed internal programming cycles. While no programming cycle is active, a read strobe returns the array word at the requested address unchanged. While the busy flag is high, reads return end-of-write status instead. Bit 7 of a read of the most recently written address carries the inverse of that byte's stored bit 7. Bit 6 changes value on every read access. Either bit lets a host detect when the cycle has finished.

The busy flag comes from the write controller. That controller also supplies the last written address and byte. A write attempt that was refused because the unlock sequence was missing still raises busy for the full timed period, so status reads work the same way during it. The read result is registered: it updates on the clock edge that samples the strobe and then holds until the next strobe. A parameter selects what the remaining bits carry during busy reads: either array data or zero.

Top module: `wstat_rdmux`

## Requirements
- R1: After reset the read bus is all zeros and the status toggle is 0, so the first busy read after reset returns 0 on bit 6.
- R2: A read strobe sampled with busy low loads the read bus with the array word, all bits, on that clock edge.
- R3: A read strobe sampled with busy high and the read address equal to the last written address loads bit 7 with the inverse of bit 7 of the last written byte.
- R4: A read strobe sampled with busy high and a different address loads bit 7 with array bit 7.
- R5: On every read strobe sampled with busy high, bit 6 shows the toggle state, and the toggle then inverts. Consecutive busy reads therefore alternate 0,1,0,...
- R6: The toggle changes only on busy read strobes. Clock cycles without a strobe leave it unchanged, and so do reads with busy low.
- R7: During busy reads, bits other than 7 and 6 carry array data when ZERO_OTHERS is 0 and carry zero when ZERO_OTHERS is 1.
- R8: Without a read strobe the read bus holds its value, even when array data changes.
- R9: The first read after busy falls returns true array data on all bits, with no inversion and no toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_stb | input | 1 | Read strobe, one cycle per read access |
| rd_addr | input | AW | Read address |
| wr_busy | input | 1 | Programming cycle in progress |
| last_addr | input | AW | Address of the last byte written |
| last_data | input | DW | Value of the last byte written |
| arr_data | input | DW | Array read data for rd_addr |
| rd_data | output | DW | Registered read bus |

## Verification
The bench builds two copies with AW=3 and DW=8: one with ZERO_OTHERS=0 and one with ZERO_OTHERS=1. Both copies see the same stimulus. The 3-bit address makes every pairing of read address and last written address reachable for a stepped set of last written byte values. Busy reads are interleaved with idle reads and strobe-free gaps, so the toggle sequence, the hold behaviour and the first read after busy falls are all compared against an arithmetic model.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY     = 2'd0,
    MODE_POLL_HIT  = 2'd1,
    MODE_POLL_MISS = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/wstat_rst_sync.sv
module wstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_busy,
  output logic tog
);
  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = rd_stb & wr_busy;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  assign tog = tog_q;

  p_toggle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_busy) |=> $stable(tog));
  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_busy) |=> (tog != $past(tog)));
endmodule

// File: rtl/wstat_compose.sv
module wstat_compose
  import wstat_pkg::*;
#(
  parameter int DW          = 8,
  parameter bit ZERO_OTHERS = 1'b0
) (
  input  rd_mode_e        mode,
  input  logic            last_msb,
  input  logic [DW-1:0]   arr_data,
  input  logic            tog,
  output logic [DW-1:0]   status
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic [DW-1:0] base;

  generate
    if (ZERO_OTHERS) begin : g_zero
      always_comb base = (mode == MODE_ARRAY) ? arr_data : '0;
    end else begin : g_pass
      always_comb base = arr_data;
    end
  endgenerate

  always_comb begin
    status = base;
    unique case (mode)
      MODE_POLL_HIT: begin
        status[POLL_BIT] = ~last_msb;
        status[TOG_BIT]  = tog;
      end
      MODE_POLL_MISS: begin
        status[POLL_BIT] = arr_data[POLL_BIT];
        status[TOG_BIT]  = tog;
      end
      default: status = arr_data;
    endcase
  end
endmodule

// File: rtl/wstat_rdmux.sv
module wstat_rdmux
  import wstat_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter bit ZERO_OTHERS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_busy,
  input  logic [AW-1:0] last_addr,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_BIT = DW - 1;

  logic          rst_sync_n;
  logic          addr_hit;
  logic          tog;
  rd_mode_e      mode;
  logic [DW-1:0] status;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_d;

  wstat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wstat_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_stb  (rd_stb),
    .wr_busy (wr_busy),
    .tog     (tog)
  );

  always_comb begin
    addr_hit = (rd_addr == last_addr);
    if (!wr_busy)      mode = MODE_ARRAY;
    else if (addr_hit) mode = MODE_POLL_HIT;
    else               mode = MODE_POLL_MISS;
  end

  wstat_compose #(.DW(DW), .ZERO_OTHERS(ZERO_OTHERS)) u_cmp (
    .mode     (mode),
    .last_msb (last_data[POLL_BIT]),
    .arr_data (arr_data),
    .tog      (tog),
    .status   (status)
  );

  always_comb rd_d = status;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_q <= '0;
    else if (rd_stb)  rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_stb |=> $stable(rd_data));
  p_idle_pass_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && !wr_busy) |=> (rd_data == $past(arr_data)));
  p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && wr_busy && rd_addr == last_addr)
      |=> (rd_data[POLL_BIT] != $past(last_data[POLL_BIT])));
  p_poll_miss_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && wr_busy && rd_addr != last_addr)
      |=> (rd_data[POLL_BIT] == $past(arr_data[POLL_BIT])));
endmodule

// File: tb/wstat_rdmux_bench.sv
module wstat_rdmux_bench;
  localparam int AW = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          wr_busy = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] rd_data_z;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  m_tog = 1'b0;

  always #5 clk = ~clk;

  wstat_rdmux #(.AW(AW), .DW(DW), .ZERO_OTHERS(1'b0)) u_wstat_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_busy(wr_busy), .last_addr(last_addr), .last_data(last_data),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  wstat_rdmux #(.AW(AW), .DW(DW), .ZERO_OTHERS(1'b1)) u_wstat_rdmux_z (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_busy(wr_busy), .last_addr(last_addr), .last_data(last_data),
    .arr_data(arr_data), .rd_data(rd_data_z)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_read(input bit busy, input logic [AW-1:0] a, input logic [AW-1:0] la,
                         input logic [DW-1:0] ld, input logic [DW-1:0] ar, input string idle_tag);
    logic [DW-1:0] e_p;
    logic [DW-1:0] e_z;
    bit hit;
    hit = (a == la);
    rd_stb = 1'b1; wr_busy = busy; rd_addr = a; last_addr = la;
    last_data = ld; arr_data = ar;
    @(negedge clk);
    rd_stb = 1'b0;
    if (!busy) begin
      chk(idle_tag, rd_data, ar);
      chk({idle_tag, "_zero_variant"}, rd_data_z, ar);
    end else begin
      e_p = ar;
      e_z = '0;
      e_p[7] = hit ? ~ld[7] : ar[7];
      e_z[7] = e_p[7];
      e_p[6] = m_tog;
      e_z[6] = m_tog;
      chk(hit ? "R3 bit7" : "R4 bit7", {7'd0, rd_data[7]}, {7'd0, e_p[7]});
      chk("R5 R6 bit6", {7'd0, rd_data[6]}, {7'd0, m_tog});
      chk("R7 pass others", rd_data & 8'h3F, e_p & 8'h3F);
      chk("R7 zero others", rd_data_z, e_z);
      m_tog = ~m_tog;
    end
  endtask

  task automatic gap(input int n);
    logic [DW-1:0] hold_p;
    logic [DW-1:0] hold_z;
    hold_p = rd_data;
    hold_z = rd_data_z;
    for (int i = 0; i < n; i++) begin
      arr_data = arr_data ^ 8'hA5;
      wr_busy = ~wr_busy;
      @(negedge clk);
    end
    chk("R8 hold", rd_data, hold_p);
    chk("R8 hold zero variant", rd_data_z, hold_z);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset bus", rd_data, 8'h00);
    chk("R1 reset bus zero variant", rd_data_z, 8'h00);
    // R1: first busy read after reset shows toggle 0
    do_read(1'b1, 3'd2, 3'd2, 8'h80, 8'h3C, "");

    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 8; k++)
        do_read(1'b0, a[AW-1:0], 3'd0, 8'h00, 8'((a * 37 + k * 29) ^ 8'h5A), "R2 idle");

    for (int ld = 0; ld < 256; ld += 17) begin
      for (int la = 0; la < 8; la++) begin
        for (int a = 0; a < 8; a++) begin
          do_read(1'b1, a[AW-1:0], la[AW-1:0], ld[7:0],
                  8'((a * 53 + la * 7 + ld) ^ 8'hC3), "");
          if (((a + la) % 3) == 0) gap((a % 3) + 1);
        end
        // R9: first read after busy falls is plain data; R6: idle read keeps toggle
        do_read(1'b0, la[AW-1:0], la[AW-1:0], ld[7:0], 8'(ld ^ 8'hFF), "R9 after busy");
        do_read(1'b0, la[AW-1:0], la[AW-1:0], ld[7:0], 8'(ld + 1), "R9 second idle");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule